// File: doc/BRIEF.md
# Cartridge Memory Bank Switching Controller

This block maps the address spaces of an 8-bit game console onto larger cartridge ROMs. The CPU writes bank numbers into a small register window at 0x7EF0–0x7EFF. The block uses them to turn each CPU program fetch and each video pattern or nametable fetch into a ROM page number or a nametable RAM page. Register writes are captured on the clock edge. The translation from bus address to page is combinational.

Program space at 0x8000–0xFFFF is split into four 8 KB windows. Windows 0–2 are switchable and window 3 is always the last bank. Pattern space is split into eight 1 KB slots:

- Slots 0–3 are served by two 2 KB registers.
- Slots 4–7 are served by four 1 KB registers.

The nametable page comes from one of two sources:

- A two-state mirroring machine with states MIR_HORZ and MIR_VERT. A write to 0x7EF6 with data bit 0 = 1 takes transition SET_VERT. A write with data bit 0 = 0 takes SET_HORZ. Any other cycle is HOLD.
- Two per-pair page bits, used instead of the mirroring machine when the program ROM is exactly 32 banks.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, windows 0..3 read banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Pattern slots 0..7 read 1 KB pages 0..7. The mirroring state is MIR_HORZ, and both per-pair page bits are 0.
- R2: A write to 0x7EFA or 0x7EFB loads window 0 (0x8000–0x9FFF). A write to 0x7EFC or 0x7EFD loads window 1 (0xA000–0xBFFF). A write to 0x7EFE or 0x7EFF loads window 2 (0xC000–0xDFFF). The window is selected by cpu_addr[14:13].
- R3: Window 3 (0xE000–0xFFFF) always reads PRG_BANKS-1, whatever was written.
- R4: The program bank output is the written byte masked to log2(PRG_BANKS) bits, so larger values wrap.
- R5: A write to 0x7EF0 sets the 2 KB bank for slots 0–1, and a write to 0x7EF1 sets it for slots 2–3. The bank is data[6:1]. The slot page is {bank, ppu_addr[10]}, and data bit 7 does not alter it.
- R6: Writes to 0x7EF2, 0x7EF3, 0x7EF4 and 0x7EF5 set the 1 KB page of slots 4, 5, 6 and 7 from the whole byte. The slot is ppu_addr[12:10].
- R7: When PRG_BANKS is not 32, the nametable page is ppu_addr[10] in MIR_VERT and ppu_addr[11] in MIR_HORZ. In that configuration, data bit 7 of 0x7EF0/0x7EF1 has no effect on the page.
- R8: When PRG_BANKS is 32, the page for nametable slots 0–1 (ppu_addr[11] = 0) is bit 7 of the last 0x7EF0 write. The page for slots 2–3 is bit 7 of the last 0x7EF1 write. The mirroring state is ignored.
- R9: A cycle with cpu_wr low, or a write to any other address, changes no output mapping.
- R10: A write changes the mapping only from the rising clock edge that samples it.
- R11: With CHR_PRESENT = 0, the pattern page is ppu_addr[12:10], unbanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address, used for register decode and program translation |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Video fetch address |
| prg_bank | output | $clog2(PRG_BANKS) | 8 KB program bank for cpu_addr |
| chr_page | output | $clog2(CHR_BANKS_1K) | 1 KB pattern page for ppu_addr |
| ntram_page | output | 1 | Nametable RAM page for ppu_addr |

## Verification
Two behaviours are hard to reach:

- The two nametable sources are chosen by an elaboration constant, so no single instance can show both. The bench therefore drives a 32-bank instance and a 16-bank, no-character-ROM instance from the same bus.
- The same 0x7EF0/0x7EF1 writes have to prove two things at once: bit 7 steers the page in one instance and is ignored in the other, and it never leaks into the pattern page.

Write timing is checked by holding a write on the bus before the sampling edge and reading the pattern page on both sides of that edge.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic {
        MIR_HORZ = 1'b0,
        MIR_VERT = 1'b1
    } mir_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PRG0,
        SEL_PRG1,
        SEL_PRG2,
        SEL_PAT2K_LO,
        SEL_PAT2K_HI,
        SEL_PAT1K_4,
        SEL_PAT1K_5,
        SEL_PAT1K_6,
        SEL_PAT1K_7,
        SEL_MIRROR
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] prg0;
        logic [7:0] prg1;
        logic [7:0] prg2;
        logic [5:0] pat2k_lo;
        logic [5:0] pat2k_hi;
        logic [7:0] pat1k_4;
        logic [7:0] pat1k_5;
        logic [7:0] pat1k_6;
        logic [7:0] pat1k_7;
        logic       nt_lo;
        logic       nt_hi;
        mir_e       mir;
    } bank_regs_t;

    // Program window registers decode on address pairs (addr[15:1]).
    localparam logic [14:0] PAIR_PRG0 = 15'h3F7D;
    localparam logic [14:0] PAIR_PRG1 = 15'h3F7E;
    localparam logic [14:0] PAIR_PRG2 = 15'h3F7F;
    localparam logic [15:0] ADR_PAT2K_LO = 16'h7EF0;
    localparam logic [15:0] ADR_PAT2K_HI = 16'h7EF1;
    localparam logic [15:0] ADR_PAT1K_4  = 16'h7EF2;
    localparam logic [15:0] ADR_PAT1K_5  = 16'h7EF3;
    localparam logic [15:0] ADR_PAT1K_6  = 16'h7EF4;
    localparam logic [15:0] ADR_PAT1K_7  = 16'h7EF5;
    localparam logic [15:0] ADR_MIRROR   = 16'h7EF6;

endpackage

// File: rtl/cbc_reg_file.sv
module cbc_reg_file
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  data,
    output bank_regs_t  regs
);

    reg_sel_e   sel;
    mir_e       mir_q;
    mir_e       mir_d;
    bank_regs_t bank_q;

    // Address decode, gated by the write strobe.
    always_comb begin
        sel = SEL_NONE;
        if (wr_en) begin
            if      (addr[15:1] == PAIR_PRG0) sel = SEL_PRG0;
            else if (addr[15:1] == PAIR_PRG1) sel = SEL_PRG1;
            else if (addr[15:1] == PAIR_PRG2) sel = SEL_PRG2;
            else if (addr == ADR_PAT2K_LO)    sel = SEL_PAT2K_LO;
            else if (addr == ADR_PAT2K_HI)    sel = SEL_PAT2K_HI;
            else if (addr == ADR_PAT1K_4)     sel = SEL_PAT1K_4;
            else if (addr == ADR_PAT1K_5)     sel = SEL_PAT1K_5;
            else if (addr == ADR_PAT1K_6)     sel = SEL_PAT1K_6;
            else if (addr == ADR_PAT1K_7)     sel = SEL_PAT1K_7;
            else if (addr == ADR_MIRROR)      sel = SEL_MIRROR;
        end
    end

    // Mirroring state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mir_q <= MIR_HORZ;
        else        mir_q <= mir_d;
    end

    // Mirroring transitions: SET_VERT, SET_HORZ, otherwise HOLD.
    always_comb begin
        mir_d = mir_q;
        unique case (mir_q)
            MIR_HORZ: if (sel == SEL_MIRROR && data[0])  mir_d = MIR_VERT;
            MIR_VERT: if (sel == SEL_MIRROR && !data[0]) mir_d = MIR_HORZ;
            default:  mir_d = MIR_HORZ;
        endcase
    end

    // Bank number registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.prg0     <= 8'd0;
            bank_q.prg1     <= 8'd1;
            bank_q.prg2     <= 8'(PRG_BANKS - 2);
            bank_q.pat2k_lo <= 6'd0;
            bank_q.pat2k_hi <= 6'd1;
            bank_q.pat1k_4  <= 8'd4;
            bank_q.pat1k_5  <= 8'd5;
            bank_q.pat1k_6  <= 8'd6;
            bank_q.pat1k_7  <= 8'd7;
            bank_q.nt_lo    <= 1'b0;
            bank_q.nt_hi    <= 1'b0;
            bank_q.mir      <= MIR_HORZ;
        end else begin
            unique case (sel)
                SEL_PRG0:     bank_q.prg0 <= data;
                SEL_PRG1:     bank_q.prg1 <= data;
                SEL_PRG2:     bank_q.prg2 <= data;
                SEL_PAT2K_LO: begin
                    bank_q.pat2k_lo <= data[6:1];
                    bank_q.nt_lo    <= data[7];
                end
                SEL_PAT2K_HI: begin
                    bank_q.pat2k_hi <= data[6:1];
                    bank_q.nt_hi    <= data[7];
                end
                SEL_PAT1K_4:  bank_q.pat1k_4 <= data;
                SEL_PAT1K_5:  bank_q.pat1k_5 <= data;
                SEL_PAT1K_6:  bank_q.pat1k_6 <= data;
                SEL_PAT1K_7:  bank_q.pat1k_7 <= data;
                default:      bank_q.mir <= bank_q.mir;
            endcase
        end
    end

    // Output process: present the registers with the live mirroring state.
    always_comb begin
        regs     = bank_q;
        regs.mir = mir_q;
    end

endmodule

// File: rtl/cbc_prg_map.sv
module cbc_prg_map
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    localparam int PRG_W = $clog2(PRG_BANKS)
) (
    input  bank_regs_t        regs,
    input  logic [15:0]       cpu_addr,
    output logic [PRG_W-1:0]  prg_bank
);

    localparam logic [7:0] LAST_BANK = 8'(PRG_BANKS - 1);

    logic [7:0] raw;
    logic       unused_prg;

    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    raw = regs.prg0;
            2'd1:    raw = regs.prg1;
            2'd2:    raw = regs.prg2;
            default: raw = LAST_BANK;
        endcase
    end

    assign prg_bank   = raw[PRG_W-1:0];
    assign unused_prg = ^{regs, raw, cpu_addr[15]};

endmodule

// File: rtl/cbc_chr_map.sv
module cbc_chr_map
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS    = 32,
    parameter int CHR_BANKS_1K = 256,
    parameter bit CHR_PRESENT  = 1'b1,
    localparam int CHR_W = $clog2(CHR_BANKS_1K),
    localparam bit NT_SEL = (PRG_BANKS == 32)
) (
    input  bank_regs_t        regs,
    input  logic [13:0]       ppu_addr,
    output logic [CHR_W-1:0]  chr_page,
    output logic              ntram_page
);

    logic [7:0] page8;
    logic       unused_chr;

    generate
        if (CHR_PRESENT) begin : g_rom
            always_comb begin
                unique case (ppu_addr[12:10])
                    3'd0, 3'd1: page8 = {1'b0, regs.pat2k_lo, ppu_addr[10]};
                    3'd2, 3'd3: page8 = {1'b0, regs.pat2k_hi, ppu_addr[10]};
                    3'd4:       page8 = regs.pat1k_4;
                    3'd5:       page8 = regs.pat1k_5;
                    3'd6:       page8 = regs.pat1k_6;
                    default:    page8 = regs.pat1k_7;
                endcase
            end
        end else begin : g_ram
            always_comb page8 = {5'd0, ppu_addr[12:10]};
        end

        if (NT_SEL) begin : g_ntsel
            always_comb ntram_page = ppu_addr[11] ? regs.nt_hi : regs.nt_lo;
        end else begin : g_mirror
            always_comb begin
                unique case (regs.mir)
                    MIR_VERT: ntram_page = ppu_addr[10];
                    default:  ntram_page = ppu_addr[11];
                endcase
            end
        end
    endgenerate

    assign chr_page   = page8[CHR_W-1:0];
    assign unused_chr = ^{regs, page8, ppu_addr[13]};

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS    = 32,
    parameter int CHR_BANKS_1K = 256,
    parameter bit CHR_PRESENT  = 1'b1,
    localparam int PRG_W = $clog2(PRG_BANKS),
    localparam int CHR_W = $clog2(CHR_BANKS_1K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic [13:0]       ppu_addr,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_page,
    output logic              ntram_page
);

    bank_regs_t regs;

    cbc_reg_file #(.PRG_BANKS(PRG_BANKS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr),
        .addr  (cpu_addr),
        .data  (cpu_data),
        .regs  (regs)
    );

    cbc_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .regs     (regs),
        .cpu_addr (cpu_addr),
        .prg_bank (prg_bank)
    );

    cbc_chr_map #(
        .PRG_BANKS    (PRG_BANKS),
        .CHR_BANKS_1K (CHR_BANKS_1K),
        .CHR_PRESENT  (CHR_PRESENT)
    ) u_chr (
        .regs       (regs),
        .ppu_addr   (ppu_addr),
        .chr_page   (chr_page),
        .ntram_page (ntram_page)
    );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    localparam int PRG_W = $clog2(PRG_BANKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr,
    input logic [15:0]      cpu_addr,
    input logic [7:0]       cpu_data,
    input bank_regs_t       regs,
    input logic [PRG_W-1:0] prg_bank
);

    assert_fixed_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_bank == PRG_W'(PRG_BANKS - 1)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(regs));

    assert_prg0_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h7EFA) |=> (regs.prg0 == $past(cpu_data)));

    assert_pat2k_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h7EF1) |=> (regs.pat2k_hi == $past(cpu_data[6:1])));

    assert_mirror_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h7EF6) |=> ((regs.mir == MIR_VERT) == $past(cpu_data[0])));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.PRG_BANKS(PRG_BANKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .regs     (regs),
    .prg_bank (prg_bank)
);

// File: tb/cart_bank_ctrl_bench.sv
`timescale 1ns/1ps
module cart_bank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic [13:0] ppu_addr = 14'h0000;
    logic [4:0]  prg_bank;
    logic [7:0]  chr_page;
    logic        ntram_page;
    logic [3:0]  prg_bank_b;
    logic [7:0]  chr_page_b;
    logic        ntram_page_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cart_bank_ctrl u_cart_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
        .chr_page(chr_page), .ntram_page(ntram_page)
    );

    cart_bank_ctrl #(.PRG_BANKS(16), .CHR_BANKS_1K(256), .CHR_PRESENT(1'b0)) u_cart_bank_ctrl_p16 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_bank(prg_bank_b),
        .chr_page(chr_page_b), .ntram_page(ntram_page_b)
    );

    // {kind(0 prg,1 chr), req, write addr, write data, probe addr, expected}
    localparam int NVEC = 18;
    localparam logic [52:0] VEC [NVEC] = '{
        {1'b0, 4'd2,  16'h7EFA, 8'h03, 16'h8000, 8'h03},  // R2
        {1'b0, 4'd2,  16'h7EFB, 8'h07, 16'h9FFF, 8'h07},  // R2 alias
        {1'b0, 4'd2,  16'h7EFC, 8'h0A, 16'hA000, 8'h0A},  // R2
        {1'b0, 4'd2,  16'h7EFD, 8'h0B, 16'hBFFF, 8'h0B},  // R2 alias
        {1'b0, 4'd2,  16'h7EFE, 8'h11, 16'hC000, 8'h11},  // R2
        {1'b0, 4'd2,  16'h7EFF, 8'h1E, 16'hDFFF, 8'h1E},  // R2 alias
        {1'b0, 4'd4,  16'h7EFA, 8'h25, 16'h8000, 8'h05},  // R4 wrap
        {1'b0, 4'd3,  16'h7EFF, 8'hFF, 16'hE000, 8'h1F},  // R3
        {1'b0, 4'd9,  16'h7EF9, 8'h00, 16'h8000, 8'h05},  // R9 unlisted
        {1'b0, 4'd9,  16'h6EFA, 8'h00, 16'h8000, 8'h05},  // R9 upper bits
        {1'b1, 4'd5,  16'h7EF0, 8'h0A, 16'h0000, 8'h0A},  // R5
        {1'b1, 4'd5,  16'h7EF0, 8'h8A, 16'h0400, 8'h0B},  // R5 bit7 no effect
        {1'b1, 4'd5,  16'h7EF1, 8'h7E, 16'h0C00, 8'h7F},  // R5
        {1'b1, 4'd6,  16'h7EF2, 8'hC8, 16'h1000, 8'hC8},  // R6
        {1'b1, 4'd6,  16'h7EF3, 8'h01, 16'h1400, 8'h01},  // R6
        {1'b1, 4'd6,  16'h7EF4, 8'hFF, 16'h1BFF, 8'hFF},  // R6
        {1'b1, 4'd6,  16'h7EF5, 8'h40, 16'h1C00, 8'h40},  // R6
        {1'b1, 4'd9,  16'h7EF7, 8'h00, 16'h1C00, 8'h40}   // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    task automatic probe_cpu(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic probe_ppu(input logic [13:0] a);
        ppu_addr = a;
        #1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        probe_cpu(16'h8000); check("R1 win0", 32'(prg_bank), 32'd0);
        probe_cpu(16'hA000); check("R1 win1", 32'(prg_bank), 32'd1);
        probe_cpu(16'hC000); check("R1 win2", 32'(prg_bank), 32'd30);
        check("R1 win2 p16", 32'(prg_bank_b), 32'd14);
        probe_cpu(16'hE000); check("R1 win3", 32'(prg_bank), 32'd31);
        check("R1 R3 win3 p16", 32'(prg_bank_b), 32'd15);
        for (int i = 0; i < 8; i++) begin
            probe_ppu(14'(i * 1024));
            check("R1 slot", 32'(chr_page), 32'(i));
        end
        for (int i = 0; i < 4; i++) begin
            probe_ppu(14'(14'h2000 + i * 1024));
            check("R1 nt page", 32'(ntram_page), 32'd0);
        end
        probe_ppu(14'h2800); check("R1 R7 horz p16", 32'(ntram_page_b), 32'd1);

        // R7 mirroring on the 16-bank instance, R8 on the 32-bank one
        wr(16'h7EF6, 8'h01);
        probe_ppu(14'h2400); check("R7 vert p16 slot1", 32'(ntram_page_b), 32'd1);
        probe_ppu(14'h2800); check("R7 vert p16 slot2", 32'(ntram_page_b), 32'd0);
        check("R8 mirror ignored", 32'(ntram_page), 32'd0);
        wr(16'h7EF6, 8'h02);
        probe_ppu(14'h2400); check("R7 horz p16 slot1", 32'(ntram_page_b), 32'd0);
        probe_ppu(14'h2800); check("R7 horz p16 slot2", 32'(ntram_page_b), 32'd1);
        wr(16'h7EF0, 8'h80);
        probe_ppu(14'h2000); check("R7 bit7 ignored p16", 32'(ntram_page_b), 32'd0);
        check("R8 lo pair sel", 32'(ntram_page), 32'd1);
        probe_ppu(14'h2400); check("R8 lo pair slot1", 32'(ntram_page), 32'd1);
        probe_ppu(14'h2800); check("R8 hi pair untouched", 32'(ntram_page), 32'd0);
        wr(16'h7EF1, 8'h80);
        probe_ppu(14'h2C00); check("R8 hi pair sel", 32'(ntram_page), 32'd1);
        wr(16'h7EF0, 8'h00);
        probe_ppu(14'h2400); check("R8 lo pair clear", 32'(ntram_page), 32'd0);
        probe_ppu(14'h2800); check("R8 hi pair kept", 32'(ntram_page), 32'd1);

        // R11 unbanked pattern space without character ROM
        wr(16'h7EF5, 8'h40);
        probe_ppu(14'h1C00); check("R11 slot7", 32'(chr_page_b), 32'd7);
        probe_ppu(14'h0400); check("R11 slot1", 32'(chr_page_b), 32'd1);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][47:32], VEC[i][31:24]);
            if (VEC[i][52] == 1'b0) begin
                probe_cpu(VEC[i][23:8]);
                n_chk++;
                if ({3'b000, prg_bank} !== VEC[i][7:0]) begin
                    n_fail++;
                    $display("FAIL R%0d prg vec %0d actual=%0h expected=%0h",
                             VEC[i][51:48], i, prg_bank, VEC[i][7:0]);
                end
            end else begin
                probe_ppu(VEC[i][21:8]);
                n_chk++;
                if (chr_page !== VEC[i][7:0]) begin
                    n_fail++;
                    $display("FAIL R%0d chr vec %0d actual=%0h expected=%0h",
                             VEC[i][51:48], i, chr_page, VEC[i][7:0]);
                end
            end
        end

        // R9 strobe low: address and data present, no write
        @(negedge clk);
        cpu_addr = 16'h7EF2; cpu_data = 8'h55; cpu_wr = 1'b0;
        ppu_addr = 14'h1000;
        @(negedge clk);
        check("R9 strobe low", 32'(chr_page), 32'hC8);

        // R10 write lands only at the sampling edge
        @(negedge clk);
        cpu_addr = 16'h7EF2; cpu_data = 8'h33; cpu_wr = 1'b1;
        #1 check("R10 before edge", 32'(chr_page), 32'hC8);
        @(posedge clk);
        #1 check("R10 after edge", 32'(chr_page), 32'h33);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R3 after many writes, window 3 still last bank
        probe_cpu(16'hFFFF); check("R3 win3 end", 32'(prg_bank), 32'd31);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule